// File: doc/BRIEF.md
# DMA Channel Control State Machine

This block holds the control/status word of one DMA channel and the state machine behind it. Software writes a command code into the control word. After a fixed, parameterised latency the channel moves between disabled, enabled, running, suspended and stopped. The current state code is reported both in the control word and on a dedicated output. A second register receives the producer offset (the doorbell). The channel is running while that offset differs from the consumed offset supplied by the descriptor engine, and enabled while the two are equal.

The `chan_active` output gates descriptor fetch in the surrounding engine. It drops as soon as a stopping command (disable, suspend or reset) has been accepted, even before that command has taken effect. A suspend waits until the transfer in flight reports completion before the state reads suspended. An error seen while the channel is active stops the channel at once, and only a reset command leaves the stopped state.

Top module: `dma_chan_ctl`

## Requirements
- R1: After `rst_n` is released, `state_code` is 0 (disabled), `chan_active` is 0, and the control word reads back 0.
- R2: The control word is at word address 0. Command codes are written in bits 23:16, and those bits read back the last accepted command. The state code reads back in bits 15:8. The doorbell is at word address 1, and its low `PTR_W` bits hold the producer offset, which reads back zero-extended.
- R3: Command 1 (enable), applied from any state except stopped, leads to state 1 (enabled) if the producer offset equals `cons_ptr`, or to state 2 (running) otherwise. `chan_active` is 1 exactly in states 1 and 2 when no stopping command is pending.
- R4: In state 1 a mismatch between producer offset and `cons_ptr` gives state 2 one clock later. In state 2 a match gives state 1 one clock later.
- R5: Command 2 (suspend), accepted while in state 1 or 2, clears `chan_active` one clock after the write. After the latency has elapsed, the state becomes 3 on the first clock at which `xfer_busy` is low. Until then the state remains 1 or 2. A suspend accepted in any other state changes nothing.
- R6: Command 0 (disable) leads to state 0 from any state except stopped. Command 9 (reset) leads to state 0 from every state, including stopped.
- R7: `err_in` high in state 1 or 2 gives state 4 (stopped) one clock later and cancels any pending command. In state 4, enable, disable and suspend have no effect.
- R8: A write of any command code other than 0, 1, 2 or 9 is ignored. The state, the command readback and any pending command are all unchanged.
- R9: When a reset command takes effect on the same clock as `err_in` is seen in an active state, the result is state 0. When any other command takes effect on that clock, the result is state 4.
- R10: A command takes effect exactly `LAT` clocks after the clock that accepted its write. A new valid command written while one is pending replaces it and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cons_ptr | input | PTR_W | Consumed offset from the descriptor engine |
| xfer_busy | input | 1 | A transfer is in flight |
| err_in | input | 1 | Error report from the channel |
| state_code | output | 8 | Current state code |
| chan_active | output | 1 | Descriptor fetch permitted |

## Verification
Two events can coincide on one clock: a pending command taking effect and an error report. The bench provokes this by counting `LAT` clocks after a reset command, and separately after a disable command. It raises `err_in` so that the error is sampled on exactly the clock where the command expires. It then checks that the reset yields state 0 while the disable yields state 4. A second overlap, a suspend that expires while `xfer_busy` is still high, is judged by confirming that the state holds at running until the busy flag falls.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int ADDR_W   = 2,
  parameter int PTR_W    = 8,
  parameter int LAT      = 4,
  parameter int CTRL_IDX = 0,
  parameter int DB_IDX   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  cons_ptr,
  input  logic              xfer_busy,
  input  logic              err_in,
  output logic [7:0]        state_code,
  output logic              chan_active
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [7:0] C_DIS = 8'd0, C_EN = 8'd1, C_SUS = 8'd2, C_RST = 8'd9;
  localparam logic [7:0] S_DIS = 8'd0, S_EN = 8'd1, S_RUN = 8'd2, S_SUS = 8'd3, S_STOP = 8'd4;

  logic [7:0]       st, pcmd, last_cmd;
  logic [PTR_W-1:0] prod;
  logic [CW-1:0]    cnt;
  logic             pend;

  wire       unused_bits = ^reg_wdata;
  wire [7:0] wcmd   = reg_wdata[23:16];
  wire       wr_ctl = reg_we && (reg_addr == ADDR_W'(CTRL_IDX));
  wire       wr_db  = reg_we && (reg_addr == ADDR_W'(DB_IDX));
  wire       known  = (wcmd == C_DIS) || (wcmd == C_EN) || (wcmd == C_SUS) || (wcmd == C_RST);
  wire       act    = (st == S_EN) || (st == S_RUN);
  wire       work   = (prod != cons_ptr);
  wire       drain  = (pcmd == C_SUS) && act && xfer_busy;
  wire       fire   = pend && (cnt == '0) && !drain;
  wire       err_hit = err_in && act;

  logic [7:0] st_nx;
  always_comb begin
    st_nx = st;
    if (fire && pcmd == C_RST)
      st_nx = S_DIS;
    else if (err_hit)
      st_nx = S_STOP;
    else if (fire) begin
      case (pcmd)
        C_DIS:   if (st != S_STOP) st_nx = S_DIS;
        C_EN:    if (st != S_STOP) st_nx = work ? S_RUN : S_EN;
        C_SUS:   if (act) st_nx = S_SUS;
        default: st_nx = st;
      endcase
    end
    else if (st == S_EN && work)
      st_nx = S_RUN;
    else if (st == S_RUN && !work)
      st_nx = S_EN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_DIS;
      pend     <= 1'b0;
      pcmd     <= C_DIS;
      last_cmd <= C_DIS;
      cnt      <= '0;
      prod     <= '0;
    end else begin
      st <= st_nx;
      if (wr_db)
        prod <= reg_wdata[PTR_W-1:0];
      if (wr_ctl && known) begin
        pend     <= 1'b1;
        pcmd     <= wcmd;
        last_cmd <= wcmd;
        cnt      <= CW'(LAT - 1);
      end else if (fire || err_hit) begin
        pend <= 1'b0;
      end else if (pend && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign state_code  = st;
  assign chan_active = act && !(pend && pcmd != C_EN);
  assign reg_rdata   = (reg_addr == ADDR_W'(CTRL_IDX)) ? {8'h00, last_cmd, st, 8'h00} :
                       (reg_addr == ADDR_W'(DB_IDX))   ? {{(32-PTR_W){1'b0}}, prod} : 32'h0;
endmodule

module dma_chan_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_busy,
  input logic       err_in,
  input logic [7:0] state_code,
  input logic       chan_active
);
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 8'd4);
  a_r3_active_states: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active |-> (state_code == 8'd1 || state_code == 8'd2));
  a_r5_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 8'd3 && xfer_busy) |=> (state_code != 8'd3));
  a_r7_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in && (state_code == 8'd1 || state_code == 8'd2)) |=> (state_code == 8'd4 || state_code == 8'd0));
  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 8'd4) |=> (state_code == 8'd4 || state_code == 8'd0));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .err_in(err_in),
  .state_code(state_code), .chan_active(chan_active)
);

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  localparam int CLK_P = 10;
  localparam int LAT   = 4;
  localparam int NV    = 8;
  // {command, producer offset, consumed offset, expected state}
  localparam logic [31:0] VEC [NV] = '{
    32'h01_00_00_01, 32'h01_03_00_02, 32'h02_03_03_03, 32'h01_05_03_02,
    32'h00_05_03_00, 32'h01_05_05_01, 32'h09_05_05_00, 32'h02_05_05_00
  };

  logic        clk = 0, rst_n = 0, reg_we = 0, xfer_busy = 0, err_in = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0]  cons_ptr = 0;
  wire  [31:0] reg_rdata;
  wire  [7:0]  state_code;
  wire         chan_active;
  int checks = 0, errors = 0;
  bit done = 0;

  dma_chan_ctl #(.LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cons_ptr(cons_ptr),
    .xfer_busy(xfer_busy), .err_in(err_in), .state_code(state_code),
    .chan_active(chan_active)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(2'd0, {8'h00, c, 16'h0000});
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    logic [31:0] r;
    tick(2); rst_n = 1; tick(1);
    rd(2'd0, r);
    chk("R1 state", state_code, 0);
    chk("R1 active", chan_active, 0);
    chk("R1 ctrl readback", r, 0);

    for (int i = 0; i < NV; i++) begin
      cons_ptr = VEC[i][15:8];
      wr(2'd1, {24'h0, VEC[i][23:16]});
      cmd(VEC[i][31:24]);
      tick(LAT);
      chk("R3/R5/R6 table state", state_code, VEC[i][7:0]);
      chk("R3 table active", chan_active, (VEC[i][7:0] == 1 || VEC[i][7:0] == 2));
      rd(2'd0, r);
      chk("R2 cmd field", r[23:16], VEC[i][31:24]);
      chk("R2 state field", r[15:8], VEC[i][7:0]);
    end
    rd(2'd1, r);
    chk("R2 doorbell readback", r, 32'h5);

    // R10 latency and restart (prod == cons == 5, state 0)
    cmd(8'd1);
    tick(LAT - 1);
    chk("R10 before latency", state_code, 0);
    tick(1);
    chk("R10 at latency", state_code, 1);
    cmd(8'd0); tick(1); cmd(8'd1);
    tick(LAT - 2);
    chk("R10 restart no early apply", state_code, 1);
    tick(2);
    chk("R10 replaced cmd applied", state_code, 1);

    // R4 enabled <-> running
    cons_ptr = 8'd6; tick(1);
    chk("R4 to running", state_code, 2);
    cons_ptr = 8'd5; tick(1);
    chk("R4 to enabled", state_code, 1);

    // R5 suspend drains in-flight transfer
    cons_ptr = 8'd2; xfer_busy = 1; tick(1);
    cmd(8'd2);
    chk("R5 active dropped", chan_active, 0);
    chk("R5 not yet suspended", state_code, 2);
    tick(LAT + 3);
    chk("R5 held while busy", state_code, 2);
    xfer_busy = 0; tick(1);
    chk("R5 suspended", state_code, 3);

    // R7 error stops, sticky
    cons_ptr = 8'd5; cmd(8'd1); tick(LAT);
    chk("R7 pre enabled", state_code, 1);
    err_in = 1; tick(1); err_in = 0;
    chk("R7 stopped", state_code, 4);
    chk("R7 inactive", chan_active, 0);
    cmd(8'd1); tick(LAT + 1);
    chk("R7 enable ignored", state_code, 4);
    cmd(8'd0); tick(LAT + 1);
    chk("R7 disable ignored", state_code, 4);
    cmd(8'd9); tick(LAT);
    chk("R6 reset leaves stopped", state_code, 0);

    // R8 unknown command ignored
    cmd(8'd1); tick(LAT);
    cmd(8'd5); tick(LAT + 1);
    rd(2'd0, r);
    chk("R8 state unchanged", state_code, 1);
    chk("R8 cmd readback unchanged", r[23:16], 1);
    cmd(8'd0); cmd(8'd7); tick(LAT - 1);
    chk("R8 pending survives", state_code, 0);

    // R9 same-cycle priority
    cmd(8'd1); tick(LAT);
    cmd(8'd9); tick(LAT - 1);
    err_in = 1; tick(1); err_in = 0;
    chk("R9 reset beats error", state_code, 0);
    cmd(8'd1); tick(LAT);
    cmd(8'd0); tick(LAT - 1);
    err_in = 1; tick(1); err_in = 0;
    chk("R9 error beats disable", state_code, 4);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule